// File: doc/BRIEF.md
# Sequenced Write-Unlock Gate

This block sits between the byte-write port of a nonvolatile array and its page load buffer, and decides whether a program cycle may change stored data. Every accepted byte write (address plus data) passes through it. Writes reach the page buffer as authorized only after a fixed three-write command sequence, and each command write must follow the one before within a load window. The command writes are used up by the gate and never reach the buffer. After an unlock, between one and `PAGE_BYTES` data bytes pass through. A program period then runs, and the gate locks again when that period ends.

A write that arrives while the gate is locked and does not open the sequence is still loaded and still starts a full program period. The page buffer sees a commit-inhibit flag and discards the load, so the device looks busy for the normal time but nothing changes. The write port follows valid/ready rules. A write is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole program period, and a source must hold its write until it is accepted. The page-buffer side has no back-pressure.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset the gate is locked: `wr_ready`=1, `busy`=0, `pb_we`=0, `pb_go`=0, `pb_commit_inhibit`=1.
- R2: After the accepted writes 0xAA to address 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, in that order, each following data byte appears on `pb_we`/`pb_addr`/`pb_data` in the cycle after it is accepted, with `pb_commit_inhibit`=0.
- R3: None of the three command writes of a matching sequence ever produces a `pb_we` pulse.
- R4: A wrong address or data on the second or third command write returns the gate to locked, and no byte is passed for that write.
- R5: A locked-state write that is not 0xAA at 0x5555 is passed with `pb_commit_inhibit`=1 and leads to a full program period.
- R6: A write accepted within `LOAD_WINDOW` cycles of the previous accepted write continues the sequence or load. A longer gap during the command sequence returns the gate to locked.
- R7: When no byte arrives for more than `LOAD_WINDOW` cycles after at least one loaded byte, `pb_go` pulses for one cycle and `busy` stays high for exactly `PROG_CYCLES` cycles.
- R8: The byte that fills the page (the `PAGE_BYTES`-th) starts programming at once: `pb_go` and `busy` are high in the same cycle as that byte's `pb_we`.
- R9: While `busy` is high, `wr_ready` is 0, no write is accepted and no `pb_we` pulse occurs after the first busy cycle.
- R10: When a program period ends the gate is locked again, so the next write without a sequence is passed with `pb_commit_inhibit`=1.
- R11: If the sequence completes but no data byte follows within the window, the gate relocks without a `pb_go` pulse or a busy period.
- R12: `pb_commit_inhibit` holds one value for the whole program period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A byte write is offered |
| wr_ready | output | 1 | Gate can accept a write (low while programming) |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | DATA_W | Byte write data |
| pb_we | output | 1 | One-cycle load strobe to the page buffer |
| pb_addr | output | ADDR_W | Address of the loaded byte |
| pb_data | output | DATA_W | Data of the loaded byte |
| pb_go | output | 1 | One-cycle pulse: program period begins |
| pb_commit_inhibit | output | 1 | Page buffer must discard the load rather than program it |
| busy | output | 1 | Program period in progress |

## Verification
The hardest conditions to reach from the ports depend on exact spacing between accepted writes: a command step that arrives on the last allowed cycle of the window, one that arrives a cycle late, and a late second step that the gate then has to treat as a fresh unauthorized first write. The stimulus places writes with explicit idle counts, so that the gap between accepting edges is exactly `LOAD_WINDOW` or `LOAD_WINDOW`+1. A full page of back-to-back writes reaches the case where programming starts on the last byte with no timeout.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
  typedef enum logic [2:0] {
    ST_LOCKED,
    ST_KEY1,
    ST_KEY2,
    ST_LOAD,
    ST_PROG
  } wp_state_e;

  localparam int KEY_STEPS = 3;

  // Command sequence, in the order the gate demands it.
  function automatic logic [14:0] key_addr(input int idx);
    case (idx)
      0:       key_addr = 15'h5555;
      1:       key_addr = 15'h2AAA;
      default: key_addr = 15'h5555;
    endcase
  endfunction

  function automatic logic [7:0] key_data(input int idx);
    case (idx)
      0:       key_data = 8'hAA;
      1:       key_data = 8'h55;
      default: key_data = 8'hA0;
    endcase
  endfunction
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
  parameter int          ADDR_W = 15,
  parameter int          DATA_W = 8,
  parameter logic [14:0] EXP_A  = 15'h0,
  parameter logic [7:0]  EXP_D  = 8'h0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(EXP_A);
  localparam logic [DATA_W-1:0] D_CMP = DATA_W'(EXP_D);

  assign hit = (addr == A_CMP) && (data == D_CMP);
endmodule

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || clear || expire) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  // R7: the count never runs past the programmed limit.
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LIMIT));
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int LOAD_WINDOW = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pb_we,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [DATA_W-1:0] pb_data,
  output logic              pb_go,
  output logic              pb_commit_inhibit,
  output logic              busy
);
  localparam int BC_W = $clog2(PAGE_BYTES + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(PAGE_BYTES - 1);

  wp_state_e            state, state_d;
  logic [KEY_STEPS-1:0] key_hit;
  logic                 accept;
  logic                 win_run, win_exp, prog_exp;
  logic                 load_byte, start_prog, set_auth, clr_auth;
  logic                 auth;
  logic [BC_W-1:0]      byte_cnt, byte_cnt_d;

  // One comparator per command step.
  for (genvar g = 0; g < KEY_STEPS; g++) begin : g_key
    wp_key_match #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .EXP_A (key_addr(g)),
      .EXP_D (key_data(g))
    ) u_match (
      .addr(wr_addr),
      .data(wr_data),
      .hit (key_hit[g])
    );
  end

  assign busy     = (state == ST_PROG);
  assign wr_ready = !busy;
  assign accept   = wr_valid && wr_ready;
  assign win_run  = (state == ST_KEY1) || (state == ST_KEY2) || (state == ST_LOAD);

  wp_gap_timer #(.LIMIT(LOAD_WINDOW)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (win_run),
    .clear (accept),
    .expire(win_exp)
  );

  wp_gap_timer #(.LIMIT(PROG_CYCLES)) u_prog (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .clear (1'b0),
    .expire(prog_exp)
  );

  always_comb begin
    state_d    = state;
    load_byte  = 1'b0;
    start_prog = 1'b0;
    set_auth   = 1'b0;
    clr_auth   = 1'b0;
    unique case (state)
      ST_LOCKED: begin
        if (accept) begin
          if (key_hit[0]) begin
            state_d = ST_KEY1;
          end else begin
            // Unauthorized write: load it inhibited.
            state_d   = ST_LOAD;
            load_byte = 1'b1;
          end
        end
      end
      ST_KEY1: begin
        if (accept)       state_d = key_hit[1] ? ST_KEY2 : ST_LOCKED;
        else if (win_exp) state_d = ST_LOCKED;
      end
      ST_KEY2: begin
        if (accept) begin
          if (key_hit[2]) begin
            state_d  = ST_LOAD;
            set_auth = 1'b1;
          end else begin
            state_d = ST_LOCKED;
          end
        end else if (win_exp) begin
          state_d = ST_LOCKED;
        end
      end
      ST_LOAD: begin
        if (accept) begin
          load_byte = 1'b1;
          if (byte_cnt == BC_FULL) begin
            state_d    = ST_PROG;
            start_prog = 1'b1;
          end
        end else if (win_exp) begin
          if (byte_cnt == '0) begin
            state_d  = ST_LOCKED;
            clr_auth = 1'b1;
          end else begin
            state_d    = ST_PROG;
            start_prog = 1'b1;
          end
        end
      end
      ST_PROG: begin
        if (prog_exp) begin
          state_d  = ST_LOCKED;
          clr_auth = 1'b1;
        end
      end
      default: state_d = ST_LOCKED;
    endcase
  end

  always_comb begin
    if (load_byte)               byte_cnt_d = (state == ST_LOAD) ? byte_cnt + 1'b1 : BC_W'(1);
    else if (state_d != ST_LOAD) byte_cnt_d = '0;
    else                         byte_cnt_d = byte_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_LOCKED;
      byte_cnt <= '0;
      auth     <= 1'b0;
      pb_we    <= 1'b0;
      pb_go    <= 1'b0;
      pb_addr  <= '0;
      pb_data  <= '0;
    end else begin
      state    <= state_d;
      byte_cnt <= byte_cnt_d;
      pb_we    <= load_byte;
      pb_go    <= start_prog;
      if (set_auth)      auth <= 1'b1;
      else if (clr_auth) auth <= 1'b0;
      if (load_byte) begin
        pb_addr <= wr_addr;
        pb_data <= wr_data;
      end
    end
  end

  assign pb_commit_inhibit = !auth;

  // R2: a load strobe always follows an accepted write.
  assert_we_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |-> $past(wr_valid && wr_ready));
  // R7: a program start coincides with a busy period.
  assert_go_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pb_go |-> busy);
  // R9: no loads once a program period is under way.
  assert_quiet_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !pb_we);
  // R12: the inhibit decision is frozen for the program period.
  assert_inhibit_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pb_commit_inhibit));
  // R10: leaving a program period always relocks.
  assert_relock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pb_commit_inhibit);
endmodule

// File: tb/sim_wp_unlock_seq.sv
module sim_wp_unlock_seq;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int PB = 64;
  localparam int LW = 16;
  localparam int PC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          pb_we, pb_go, pb_commit_inhibit, busy;
  logic [AW-1:0] pb_addr;
  logic [DW-1:0] pb_data;

  int checks = 0;
  int errors = 0;
  int go_cnt = 0;
  int we_cnt = 0;
  int busy_len = 0;
  logic [23:0] expq[$];

  always #5ns clk = ~clk;

  wp_unlock_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB),
    .LOAD_WINDOW(LW), .PROG_CYCLES(PC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pb_we(pb_we), .pb_addr(pb_addr),
    .pb_data(pb_data), .pb_go(pb_go), .pb_commit_inhibit(pb_commit_inhibit),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge, offers one write for one cycle.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit passed, input bit inh);
    if (passed) expq.push_back({a, d, inh});
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(15'h5555, 8'hAA, 0, 0);
    wr(15'h2AAA, 8'h55, 0, 0);
    wr(15'h5555, 8'hA0, 0, 0);
  endtask

  task automatic finish_prog();
    idle(LW + 1);
    while (busy) @(negedge clk);
    idle(2);
  endtask

  // Monitor: compares each load against the scoreboard, times busy periods.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pb_we) begin
        we_cnt++;
        if (expq.size() == 0) begin
          chk(0, "R3 unexpected load", int'(pb_addr), 0);
        end else begin
          automatic logic [23:0] e = expq.pop_front();
          chk({pb_addr, pb_data, pb_commit_inhibit} == e, "R2/R5 load contents",
              int'({pb_addr, pb_data, pb_commit_inhibit}), int'(e));
        end
      end
      if (pb_go) go_cnt++;
      if (busy) busy_len++;
      else if (busy_len != 0) begin
        chk(busy_len == PC, "R7 busy length", busy_len, PC);
        busy_len = 0;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2ms;
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int g0, w0;
    idle(3);
    chk(pb_commit_inhibit && wr_ready && !busy && !pb_we && !pb_go, "R1 reset state",
        {pb_commit_inhibit, wr_ready, busy, pb_we, pb_go}, 5'b11000);
    rst_n = 1'b1;
    idle(2);
    chk(pb_commit_inhibit && wr_ready && !busy, "R1 after release",
        {pb_commit_inhibit, wr_ready, busy}, 3'b110);

    // R2, R3: authorized load of three bytes
    w0 = we_cnt;
    unlock();
    chk(we_cnt == w0, "R3 command writes not passed", we_cnt - w0, 0);
    chk(!pb_commit_inhibit, "R2 unlocked", pb_commit_inhibit, 0);
    wr(15'h0040, 8'h11, 1, 0);
    wr(15'h0043, 8'h22, 1, 0);
    wr(15'h0041, 8'h33, 1, 0);
    g0 = go_cnt;
    idle(LW + 1);
    chk(go_cnt == g0 + 1 && busy, "R7 program after window", go_cnt - g0, 1);
    chk(!pb_commit_inhibit, "R12 inhibit low in authorized program", pb_commit_inhibit, 0);
    // R9: offer writes while busy
    wr_valid = 1'b1; wr_addr = 15'h0044; wr_data = 8'h99;
    idle(1);
    chk(!wr_ready, "R9 not ready while busy", wr_ready, 0);
    idle(3);
    wr_valid = 1'b0;
    finish_prog();
    chk(pb_commit_inhibit, "R10 relocked after program", pb_commit_inhibit, 1);

    // R10, R5: write without sequence is inhibited, still programs
    g0 = go_cnt;
    wr(15'h0041, 8'h77, 1, 1);
    finish_prog();
    chk(go_cnt == g0 + 1, "R5 dummy program ran", go_cnt - g0, 1);

    // R4: wrong data on the second step
    wr(15'h5555, 8'hAA, 0, 0);
    wr(15'h2AAA, 8'h54, 0, 0);
    wr(15'h0100, 8'h12, 1, 1);
    finish_prog();
    // R4: wrong address on the third step
    wr(15'h5555, 8'hAA, 0, 0);
    wr(15'h2AAA, 8'h55, 0, 0);
    wr(15'h5554, 8'hA0, 0, 0);
    chk(pb_commit_inhibit, "R4 third step mismatch relocks", pb_commit_inhibit, 1);
    wr(15'h0101, 8'h34, 1, 1);
    finish_prog();

    // R6: steps exactly LOAD_WINDOW cycles apart still unlock
    wr(15'h5555, 8'hAA, 0, 0); idle(LW - 1);
    wr(15'h2AAA, 8'h55, 0, 0); idle(LW - 1);
    wr(15'h5555, 8'hA0, 0, 0); idle(LW - 1);
    chk(!pb_commit_inhibit, "R6 gap of window accepted", pb_commit_inhibit, 0);
    wr(15'h0200, 8'h5A, 1, 0); idle(LW - 1);
    wr(15'h0201, 8'hA5, 1, 0);
    finish_prog();
    // R6: one cycle too late; the late step becomes an unauthorized first write
    wr(15'h5555, 8'hAA, 0, 0); idle(LW);
    wr(15'h2AAA, 8'h55, 1, 1);
    finish_prog();

    // R8: full page back to back
    unlock();
    for (int i = 0; i < PB - 1; i++) wr(AW'(15'h0300 + i), DW'(i), 1, 0);
    wr(AW'(15'h0300 + PB - 1), 8'hEE, 1, 0);
    chk(pb_we && pb_go && busy, "R8 program starts on last byte",
        {pb_we, pb_go, busy}, 3'b111);
    finish_prog();

    // R11: sequence with no data relocks silently
    g0 = go_cnt;
    unlock();
    idle(LW + 3);
    chk(!busy && go_cnt == g0, "R11 no program without data", go_cnt - g0, 0);
    chk(pb_commit_inhibit, "R11 relocked", pb_commit_inhibit, 1);
    wr(15'h0400, 8'h66, 1, 1);
    finish_prog();

    chk(expq.size() == 0, "R2 all expected loads seen", expq.size(), 0);
    summary();
  end
endmodule